// File: doc/BRIEF.md
# Processor Power-State Sequencer

This block steps a processor core through its power states: running, halted, stop-granted, and a probe state that the system controller can force while the core is parked. It decides when the core may drop into its low-power clock mode. It asks the system controller for the special bus cycles that announce a halt or a stop grant, and for a bus connect when the core must wake up. While a stop grant is in force, it collects wake events so that the core sees them once it runs again.

The core reports a halt instruction with a strobe. The chipset drives a stop-clock request. The system controller reports whether the bus is connected, acknowledges each special cycle, and requests and ends probes. The low-power mode is taken from a static configuration word. The block only enables that mode after the relevant special cycle has been acknowledged and the bus has been disconnected. The special-cycle requests carry back-pressure: each request is a one-cycle pulse, and no further request is issued until `cyc_ack` has returned for the previous one. A request that is still waiting when the bus is disconnected waits until the bus is connected again.

Top module: `pwr_state_seq`

## Requirements
- R1: A `halt_instr` strobe in the running state moves the block to Halt, and a one-cycle `halt_cyc` pulse follows on the second cycle after the strobe when the bus is connected and no special cycle is outstanding.
- R2: `lp_en` is high only in Halt or Stop Grant, only after that state's special cycle has been acknowledged, and only while `bus_conn` is low. `lp_ctl` equals `clk_ctl_cfg` while `lp_en` is high and zero otherwise.
- R3: `stop_clk` in the running state or in Halt moves the block to Stop Grant. It takes priority over a halt strobe and over wake events in the same cycle. `conn_req` is raised while the bus is disconnected, and a one-cycle `stpg_cyc` pulse is issued once the bus is connected.
- R4: When `stop_clk` falls in a Stop Grant that was entered from Halt, the block returns to Halt and issues a fresh `halt_cyc` pulse.
- R5: Any bit of `wake_evt` in Halt returns the block to the running state. A one-cycle `resume` pulse is produced, and `conn_req` is raised while the bus is disconnected.
- R6: In Stop Grant, and in a probe taken from Stop Grant, each `wake_evt` bit is captured into the sticky `pend_evt` bit of the same position. The bit order is init 0, SMI 1, INTR 2, NMI 3, local interrupt message 4.
- R7: Stop Grant is left only when `stop_clk` falls or `sys_reset` is asserted. Wake events leave `lp_en` unchanged. A Stop Grant entered from the running state returns there with a `resume` pulse and a `conn_req` while the bus is disconnected.
- R8: `bus_conn` together with `probe_req` in Halt or Stop Grant enters Probe, where `lp_en` is low. `probe_done` returns the block to the state it came from without a new special cycle, and low power resumes only once the bus is disconnected again.
- R9: A rising `sys_reset` gives a one-cycle `reset_start` pulse on the next cycle. From any state, `sys_reset` returns the block to the running state, clears `pend_evt`, drops any special cycle that has not yet been issued, and gives no `resume` pulse.
- R10: `pend_evt` stays set through the `resume` pulse and reads zero from the cycle after it.
- R11: A special cycle is not issued while an earlier one is still waiting for `cyc_ack`. It is issued on the cycle after the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| halt_instr | input | 1 | One-cycle strobe from the core when a halt instruction executes |
| stop_clk | input | 1 | Stop-clock request level |
| sys_reset | input | 1 | Processor reset request |
| wake_evt | input | WAKE_N | Wake events: init, SMI, INTR, NMI, local interrupt message (bits 0 to 4) |
| bus_conn | input | 1 | System bus connected status |
| probe_req | input | 1 | System controller wants to probe the core |
| probe_done | input | 1 | Probes are complete |
| cyc_ack | input | 1 | Acknowledge of the outstanding special cycle |
| clk_ctl_cfg | input | CTL_W | Low-power clock-control setting |
| halt_cyc | output | 1 | Halt special-cycle request pulse |
| stpg_cyc | output | 1 | Stop Grant special-cycle request pulse |
| conn_req | output | 1 | Request to connect the system bus |
| lp_en | output | 1 | Low-power mode enable |
| lp_ctl | output | CTL_W | Applied low-power setting |
| pend_evt | output | WAKE_N | Wake events latched during Stop Grant |
| resume | output | 1 | Pulse on the return to the running state |
| reset_start | output | 1 | Pulse that starts the reset sequence |

## Verification
The bench drives `stop_clk` and a wake event in the same cycle while the block sits in low-power Halt. The stop request must win. The bench judges this from the missing `resume` pulse, the raised `conn_req`, and the wake bit that shows up in `pend_evt`. It also raises `halt_instr` and `stop_clk` together in the running state and expects only a `stpg_cyc` pulse. Finally, it lets a Stop Grant request collide with an unacknowledged Halt cycle, and checks that `stpg_cyc` waits until the cycle after `cyc_ack`.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_HALT  = 2'd1,
    PS_STPG  = 2'd2,
    PS_PROBE = 2'd3
  } pstate_e;

  typedef enum logic {
    CYC_HALT = 1'b0,
    CYC_STPG = 1'b1
  } cyc_kind_e;

  localparam int unsigned WAKE_SRC_N = 5;
endpackage

// File: rtl/pwr_cycle_issue.sv
module pwr_cycle_issue
  import pwr_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  cyc_kind_e load_kind,
  input  logic      drop,
  input  logic      bus_conn,
  input  logic      ack,
  output logic      halt_p,
  output logic      stpg_p,
  output logic      done
);
  logic      pend_q;
  logic      outst_q;
  cyc_kind_e kind_q;
  logic      fire;

  // A waiting cycle goes out only on a connected bus with nothing outstanding
  assign fire = pend_q && bus_conn && !outst_q && !drop && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      outst_q <= 1'b0;
      kind_q  <= CYC_HALT;
      halt_p  <= 1'b0;
      stpg_p  <= 1'b0;
      done    <= 1'b0;
    end else begin
      halt_p <= fire && (kind_q == CYC_HALT);
      stpg_p <= fire && (kind_q == CYC_STPG);
      if (ack && outst_q) outst_q <= 1'b0;
      if (fire)           outst_q <= 1'b1;
      if (drop) begin
        pend_q  <= 1'b0;
        outst_q <= 1'b0;
        done    <= 1'b0;
      end else if (load) begin
        pend_q <= 1'b1;
        kind_q <= load_kind;
        done   <= 1'b0;
      end else begin
        if (fire) pend_q <= 1'b0;
        if (ack && outst_q && !pend_q) done <= 1'b1;
      end
    end
  end

  // R11: an outstanding, unacknowledged cycle blocks the next issue
  a_r11_no_issue_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (outst_q && !ack) |=> !(halt_p || stpg_p));

  // R1: each request is a single-cycle pulse
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_p || stpg_p) |=> !(halt_p || stpg_p));

  a_r1_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_p && stpg_p));
endmodule

// File: rtl/pwr_wake_latch.sv
module pwr_wake_latch #(
  parameter int unsigned WAKE_N = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              clr,
  input  logic [WAKE_N-1:0] evt,
  output logic [WAKE_N-1:0] pend
);
  for (genvar b = 0; b < WAKE_N; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[b] <= 1'b0;
      else        pend[b] <= (pend[b] && !clr) || (cap_en && evt[b]);
    end

    // R6: a captured event stays until cleared
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[b] && !clr) |=> pend[b]);
  end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned WAKE_N = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_instr,
  input  logic              stop_clk,
  input  logic              sys_reset,
  input  logic [WAKE_N-1:0] wake_evt,
  input  logic              bus_conn,
  input  logic              probe_req,
  input  logic              probe_done,
  output logic              low_ctx,
  output logic              cap_en,
  output logic              cap_clr,
  output logic              cyc_load,
  output cyc_kind_e         cyc_kind,
  output logic              cyc_drop,
  output logic              conn_req,
  output logic              resume,
  output logic              reset_start
);
  pstate_e state_q, nxt;
  logic    ret_stpg_q, nxt_ret;
  logic    from_halt_q, nxt_fh;
  logic    conn_need_q, set_conn;
  logic    sysrst_q;
  logic    any_wake, probe_go;

  assign any_wake = |wake_evt;
  assign probe_go = bus_conn && probe_req;

  always_comb begin
    nxt      = state_q;
    nxt_ret  = ret_stpg_q;
    nxt_fh   = from_halt_q;
    cyc_load = 1'b0;
    cyc_kind = CYC_HALT;
    cyc_drop = 1'b0;
    set_conn = 1'b0;
    if (sys_reset) begin
      nxt      = PS_RUN;
      cyc_drop = 1'b1;
    end else begin
      unique case (state_q)
        PS_RUN: begin
          if (stop_clk) begin
            nxt      = PS_STPG;
            nxt_fh   = 1'b0;
            cyc_load = 1'b1;
            cyc_kind = CYC_STPG;
          end else if (halt_instr) begin
            nxt      = PS_HALT;
            cyc_load = 1'b1;
          end
        end
        PS_HALT: begin
          if (stop_clk) begin
            nxt      = PS_STPG;
            nxt_fh   = 1'b1;
            cyc_load = 1'b1;
            cyc_kind = CYC_STPG;
            set_conn = 1'b1;
          end else if (any_wake) begin
            nxt      = PS_RUN;
            cyc_drop = 1'b1;
            set_conn = 1'b1;
          end else if (probe_go) begin
            nxt     = PS_PROBE;
            nxt_ret = 1'b0;
          end
        end
        PS_STPG: begin
          if (!stop_clk) begin
            set_conn = 1'b1;
            if (from_halt_q) begin
              nxt      = PS_HALT;
              cyc_load = 1'b1;
            end else begin
              nxt      = PS_RUN;
              cyc_drop = 1'b1;
            end
          end else if (probe_go) begin
            nxt     = PS_PROBE;
            nxt_ret = 1'b1;
          end
        end
        default: begin
          if (probe_done) nxt = ret_stpg_q ? PS_STPG : PS_HALT;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PS_RUN;
      ret_stpg_q  <= 1'b0;
      from_halt_q <= 1'b0;
      conn_need_q <= 1'b0;
      resume      <= 1'b0;
      reset_start <= 1'b0;
      sysrst_q    <= 1'b0;
    end else begin
      state_q     <= nxt;
      ret_stpg_q  <= nxt_ret;
      from_halt_q <= nxt_fh;
      sysrst_q    <= sys_reset;
      reset_start <= sys_reset && !sysrst_q;
      resume      <= (state_q != PS_RUN) && (nxt == PS_RUN) && !sys_reset;
      if (sys_reset)     conn_need_q <= 1'b0;
      else if (set_conn) conn_need_q <= 1'b1;
      else if (bus_conn) conn_need_q <= 1'b0;
    end
  end

  assign low_ctx  = (state_q == PS_HALT) || (state_q == PS_STPG);
  assign conn_req = conn_need_q && !bus_conn;
  assign cap_clr  = resume || sys_reset;
  assign cap_en   = !sys_reset &&
                    ((state_q == PS_STPG) || (nxt == PS_STPG) ||
                     ((state_q == PS_PROBE) && ret_stpg_q));

  // R7: held stop-clock without reset or probe keeps Stop Grant
  a_r7_stpg_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_STPG && stop_clk && !sys_reset && !probe_go)
      |=> state_q == PS_STPG);

  // R9: reset request launches the reset pulse
  a_r9_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_reset) |=> reset_start);

  a_r9_no_resume_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |=> !resume);

  // R10: resume lasts one cycle
  a_r10_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);

  // R8: probe ends in a parked state, never the running state
  a_r8_probe_return: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_PROBE && probe_done && !sys_reset) |=> low_ctx);
endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CTL_W  = 3,
  parameter int unsigned WAKE_N = WAKE_SRC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_instr,
  input  logic              stop_clk,
  input  logic              sys_reset,
  input  logic [WAKE_N-1:0] wake_evt,
  input  logic              bus_conn,
  input  logic              probe_req,
  input  logic              probe_done,
  input  logic              cyc_ack,
  input  logic [CTL_W-1:0]  clk_ctl_cfg,
  output logic              halt_cyc,
  output logic              stpg_cyc,
  output logic              conn_req,
  output logic              lp_en,
  output logic [CTL_W-1:0]  lp_ctl,
  output logic [WAKE_N-1:0] pend_evt,
  output logic              resume,
  output logic              reset_start
);
  logic      low_ctx, cap_en, cap_clr;
  logic      cyc_load, cyc_drop, cyc_done;
  cyc_kind_e cyc_kind;

  pwr_seq_fsm #(.WAKE_N(WAKE_N)) u_fsm (
    .clk(clk), .rst_n(rst_n), .halt_instr(halt_instr), .stop_clk(stop_clk),
    .sys_reset(sys_reset), .wake_evt(wake_evt), .bus_conn(bus_conn),
    .probe_req(probe_req), .probe_done(probe_done), .low_ctx(low_ctx),
    .cap_en(cap_en), .cap_clr(cap_clr), .cyc_load(cyc_load),
    .cyc_kind(cyc_kind), .cyc_drop(cyc_drop), .conn_req(conn_req),
    .resume(resume), .reset_start(reset_start)
  );

  pwr_cycle_issue u_issue (
    .clk(clk), .rst_n(rst_n), .load(cyc_load), .load_kind(cyc_kind),
    .drop(cyc_drop), .bus_conn(bus_conn), .ack(cyc_ack),
    .halt_p(halt_cyc), .stpg_p(stpg_cyc), .done(cyc_done)
  );

  pwr_wake_latch #(.WAKE_N(WAKE_N)) u_latch (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .clr(cap_clr),
    .evt(wake_evt), .pend(pend_evt)
  );

  assign lp_en  = low_ctx && cyc_done && !bus_conn;
  assign lp_ctl = lp_en ? clk_ctl_cfg : '0;

  // R2: low power only in a parked state with the bus released
  a_r2_lp_parked: assert property (@(posedge clk) disable iff (!rst_n)
    lp_en |-> (low_ctx && !bus_conn));

  a_r2_lp_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    lp_en |-> !(halt_cyc || stpg_cyc));
endmodule

// File: tb/sim_pwr_state_seq.sv
`timescale 1ns/1ps
module sim_pwr_state_seq;
  localparam int CTL_W  = 3;
  localparam int WAKE_N = 5;

  logic clk = 1'b0;
  logic rst_n, halt_instr, stop_clk, sys_reset, bus_conn, probe_req, probe_done, cyc_ack;
  logic [WAKE_N-1:0] wake_evt;
  logic [CTL_W-1:0]  clk_ctl_cfg;
  logic halt_cyc, stpg_cyc, conn_req, lp_en, resume, reset_start;
  logic [CTL_W-1:0]  lp_ctl;
  logic [WAKE_N-1:0] pend_evt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pwr_state_seq #(.CTL_W(CTL_W), .WAKE_N(WAKE_N)) u0 (
    .clk(clk), .rst_n(rst_n), .halt_instr(halt_instr), .stop_clk(stop_clk),
    .sys_reset(sys_reset), .wake_evt(wake_evt), .bus_conn(bus_conn),
    .probe_req(probe_req), .probe_done(probe_done), .cyc_ack(cyc_ack),
    .clk_ctl_cfg(clk_ctl_cfg), .halt_cyc(halt_cyc), .stpg_cyc(stpg_cyc),
    .conn_req(conn_req), .lp_en(lp_en), .lp_ctl(lp_ctl), .pend_evt(pend_evt),
    .resume(resume), .reset_start(reset_start)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Halt with acknowledged cycle, then bus released: low power
  task automatic park_in_halt();
    halt_instr = 1'b1; tick(); halt_instr = 1'b0;
    tick(); chk("R1 halt_cyc pulse", halt_cyc, 1);
    cyc_ack = 1'b1; tick(); cyc_ack = 1'b0;
    chk("R1 halt_cyc single", halt_cyc, 0);
    chk("R2 no lp while connected", lp_en, 0);
    bus_conn = 1'b0; tick();
    chk("R2 lp after disconnect", lp_en, 1);
    chk("R2 lp_ctl follows cfg", lp_ctl, clk_ctl_cfg);
  endtask

  initial begin
    rst_n = 1'b0; halt_instr = 0; stop_clk = 0; sys_reset = 0; bus_conn = 1;
    probe_req = 0; probe_done = 0; cyc_ack = 0; wake_evt = '0; clk_ctl_cfg = 3'd5;
    repeat (3) tick();
    rst_n = 1'b1; tick();
    chk("reset lp_en", lp_en, 0);
    chk("reset cycles", {halt_cyc, stpg_cyc}, 0);
    chk("reset pulses", {resume, reset_start, conn_req}, 0);
    chk("reset pend", pend_evt, 0);

    // R1 R2 R5: halt exit by each wake source
    for (int i = 0; i < WAKE_N; i++) begin
      clk_ctl_cfg = CTL_W'(i + 2);
      park_in_halt();
      wake_evt = WAKE_N'(1 << i); tick(); wake_evt = '0;
      chk("R5 resume on wake", resume, 1);
      chk("R5 conn_req when disconnected", conn_req, 1);
      chk("R2 lp off in run", lp_en, 0);
      chk("R2 lp_ctl zero", lp_ctl, 0);
      bus_conn = 1'b1; tick();
      chk("R5 resume single", resume, 0);
      chk("R5 conn_req cleared", conn_req, 0);
    end

    // R3 R4 R6 R10: stop grant from halt, each event latched
    for (int i = 0; i < WAKE_N; i++) begin
      park_in_halt();
      stop_clk = 1'b1; tick();
      chk("R3 conn_req in stop grant", conn_req, 1);
      chk("R3 lp off until stpg cycle", lp_en, 0);
      chk("R3 no stpg before connect", stpg_cyc, 0);
      bus_conn = 1'b1; tick();
      chk("R3 stpg_cyc pulse", stpg_cyc, 1);
      cyc_ack = 1'b1; tick(); cyc_ack = 1'b0; bus_conn = 1'b0; tick();
      chk("R3 lp in stop grant", lp_en, 1);
      wake_evt = WAKE_N'(1 << i); tick(); wake_evt = '0; tick();
      chk("R6 event latched", pend_evt, 1 << i);
      chk("R7 wake does not leave stop grant", lp_en, 1);
      stop_clk = 1'b0; tick();
      chk("R4 conn_req back to halt", conn_req, 1);
      chk("R4 no resume to halt", resume, 0);
      bus_conn = 1'b1; tick();
      chk("R4 fresh halt_cyc", halt_cyc, 1);
      cyc_ack = 1'b1; tick(); cyc_ack = 1'b0;
      wake_evt = WAKE_N'(1 << ((i + 1) % WAKE_N)); tick(); wake_evt = '0;
      chk("R10 resume", resume, 1);
      chk("R10 pend held during resume", pend_evt, 1 << i);
      tick();
      chk("R10 pend cleared", pend_evt, 0);
    end

    // R3 R7 R8: stop grant from run, halt strobe collides, probe inside
    stop_clk = 1'b1; halt_instr = 1'b1; tick(); halt_instr = 1'b0;
    tick();
    chk("R3 stop wins over halt", {halt_cyc, stpg_cyc}, 2'b01);
    cyc_ack = 1'b1; tick(); cyc_ack = 1'b0; bus_conn = 1'b0; tick();
    chk("R3 lp in stop grant", lp_en, 1);
    bus_conn = 1'b1; probe_req = 1'b1; tick(); probe_req = 1'b0;
    chk("R8 probe lp off", lp_en, 0);
    wake_evt = 5'b01000; tick(); wake_evt = '0;
    probe_done = 1'b1; tick(); probe_done = 1'b0;
    chk("R6 latched in probe", pend_evt, 5'b01000);
    chk("R8 lp off while connected", lp_en, 0);
    tick();
    chk("R8 no new cycle after probe", {halt_cyc, stpg_cyc}, 0);
    bus_conn = 1'b0; tick();
    chk("R8 lp after disconnect", lp_en, 1);
    stop_clk = 1'b0; tick();
    chk("R7 resume from stop grant", resume, 1);
    chk("R7 conn_req", conn_req, 1);
    bus_conn = 1'b1; tick();
    chk("R10 pend cleared", pend_evt, 0);

    // R8: probe from halt returns to halt
    park_in_halt();
    bus_conn = 1'b1; probe_req = 1'b1; tick(); probe_req = 1'b0;
    chk("R8 probe lp off", lp_en, 0);
    probe_done = 1'b1; tick(); probe_done = 1'b0; tick();
    chk("R8 no halt_cyc after probe", halt_cyc, 0);
    bus_conn = 1'b0; tick();
    chk("R8 lp back in halt", lp_en, 1);
    wake_evt = 5'b00001; tick(); wake_evt = '0;
    chk("R8 halt wake after probe", resume, 1);
    bus_conn = 1'b1; tick();

    // R9: reset inside stop grant
    stop_clk = 1'b1; tick(); tick();
    wake_evt = 5'b00100; tick(); wake_evt = '0;
    chk("R6 latched before reset", pend_evt, 5'b00100);
    sys_reset = 1'b1; tick();
    chk("R9 reset_start", reset_start, 1);
    chk("R9 pend cleared", pend_evt, 0);
    chk("R9 no resume", resume, 0);
    tick();
    chk("R9 reset_start single", reset_start, 0);
    chk("R9 pending cycle dropped", stpg_cyc, 0);
    sys_reset = 1'b0; stop_clk = 1'b0; tick();

    // R11: stop grant request waits for ack of halt cycle
    halt_instr = 1'b1; tick(); halt_instr = 1'b0;
    tick(); chk("R1 halt_cyc", halt_cyc, 1);
    stop_clk = 1'b1; tick(); tick();
    chk("R11 blocked while outstanding", stpg_cyc, 0);
    tick();
    chk("R11 still blocked", stpg_cyc, 0);
    cyc_ack = 1'b1; tick(); cyc_ack = 1'b0;
    chk("R11 not in ack cycle", stpg_cyc, 0);
    tick();
    chk("R11 issued after ack", stpg_cyc, 1);
    cyc_ack = 1'b1; tick(); cyc_ack = 1'b0;
    stop_clk = 1'b0; tick(); tick();
    chk("R4 halt_cyc after stop", halt_cyc, 1);
    cyc_ack = 1'b1; tick(); cyc_ack = 1'b0;
    wake_evt = 5'b00010; tick(); wake_evt = '0; tick();

    // R3 R6: stop request and wake event in the same cycle in halt
    park_in_halt();
    stop_clk = 1'b1; wake_evt = 5'b10000; tick(); wake_evt = '0;
    chk("R3 stop wins over wake", resume, 0);
    chk("R3 conn_req", conn_req, 1);
    tick();
    chk("R6 collided event latched", pend_evt, 5'b10000);
    bus_conn = 1'b1; tick(); cyc_ack = 1'b1; tick(); cyc_ack = 1'b0;
    stop_clk = 1'b0; tick(); tick(); cyc_ack = 1'b1; tick(); cyc_ack = 1'b0;
    wake_evt = 5'b00001; tick(); wake_evt = '0;
    chk("R10 resume after collision", resume, 1);
    tick();
    chk("R10 pend cleared", pend_evt, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule